// File: doc/BRIEF.md
# Banked Shared Signal Memory with Slot Sequencer

This block is the shared sample store of a modular synthesizer. Each module output owns one word. Each module input fetches any word once per sample period. The store is split into parallel banks of equal depth. Because every word is refreshed at a fixed address each period, one write slot stores word `w` in every bank together. A full refresh therefore costs only as many write slots as a bank has words, not one slot per word.

A free-running slot sequencer divides the sample period into two phases:

- **Write phase.** Block-write slots of two clocks each come first. The sequencer publishes the word index being filled, and the producers place one word per bank on a wide write bus.
- **Read phase.** Single-clock read slots follow. The sequencer names the input being served, and the consumer presents an address. The data comes back one clock later, tagged with the same input index.

A parameter can build one or two identical copies of the array. Both copies take the same writes. With two copies, the inputs are split in half between two read ports, and the read phase becomes half as long.

Top module: `smem_top`

## Requirements
- R1: The sample period is `2*BDEPTH + NREAD/NPORT` clocks. `sample_strobe` is high for exactly one clock, at slot position 0. Position 0 is the first clock after reset is released, and the strobe then recurs every period.
- R2: Positions 0 to `2*BDEPTH-1` form the write phase. During it, `wr_ready` is high, `rd_valid` is low, and `wr_index` equals position/2. Each index is therefore held for two clocks, in ascending order from 0.
- R3: `wr_data` is sampled at the clock edge that ends the second clock of each write slot. Bits `b*DW +: DW` are stored at word `wr_index` of bank `b`, for all banks at once and in every copy.
- R4: The remaining positions form the read phase. During it, `rd_valid` is high and `wr_ready` is low. In read slot `r` (position minus `2*BDEPTH`), port `p` serves input `p*NREAD/NPORT + r`, shown on `rd_idx[p*IW +: IW]`. Outside the read phase, `rd_idx` is zero.
- R5: A read address has the bank number in its upper bits and the word-in-bank in its lower `$clog2(BDEPTH)` bits. With the defaults, the address is 9 bits: bank in bits 8:4 and word in bits 3:0. The address on `rd_addr[p*AW +: AW]` is taken at the edge that ends the read slot. One clock later, `rd_dvalid` is high, and `rd_didx` repeats that slot's `rd_idx`.
- R6: A read returns the word stored for that bank and word during the write phase of the same sample period.
- R7: A read whose bank field is `NBANK` or above returns zero. `rd_data` is zero in every clock where `rd_dvalid` is low.
- R8: With two copies, both read ports see identical contents. The same address on both ports returns the same word.
- R9: While `rst` is high, every output is zero and no slot advances.
- R10: `wr_data` is ignored in every clock other than the second clock of a write slot. This includes the first clock of each write slot and the whole read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | NBANK*DW | One word per bank for the current write slot |
| rd_addr | input | NPORT*AW | Read address per port, {bank, word} |
| sample_strobe | output | 1 | High at slot position 0 of each period |
| wr_ready | output | 1 | Write phase in progress |
| wr_index | output | $clog2(BDEPTH) | Word index being filled in every bank |
| rd_valid | output | 1 | Read phase in progress, address taken this clock |
| rd_idx | output | NPORT*IW | Input index served per port in this read slot |
| rd_dvalid | output | 1 | Read data valid |
| rd_didx | output | NPORT*IW | Input index that the returned data belongs to |
| rd_data | output | NPORT*DW | Returned word per port |

## Verification
The bench keeps 18 banks of 16 words of 16 bits and 288 inputs, but builds two mirrored copies (NPORT=2). This gives a 176-clock period, so four full periods with distinct stored patterns run in well under a thousand clocks. The two-copy build reaches the split input numbering and the port-to-port mirror check, which a single-copy build cannot show. A 5-bit bank field with only 18 banks leaves addresses 288 to 511 available for the zero-return case.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/smem_seq.sv
// Slot sequencer: write phase of 2-clock block-write slots, then 1-clock read slots.
module smem_seq
  import smem_pkg::*;
#(
  parameter int BDEPTH = 16,
  parameter int RSLOTS = 288,
  parameter int NPORT  = 1,
  parameter int IW     = 9,
  parameter int WORDW  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic                  strobe,
  output logic                  wr_ready,
  output logic                  wr_commit,
  output logic [WORDW-1:0]      wr_index,
  output logic                  rd_valid,
  output logic [NPORT*IW-1:0]   rd_idx
);

  localparam int WRCLK  = 2 * BDEPTH;
  localparam int PERIOD = WRCLK + RSLOTS;
  localparam int CW     = bits_for(PERIOD);

  logic [CW-1:0]       cnt_q, cnt_d, slot_d;
  phase_e              ph_d;
  logic [NPORT*IW-1:0] rd_idx_d;

  always_comb begin
    cnt_d  = (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
    ph_d   = (cnt_d < CW'(WRCLK)) ? PH_WRITE : PH_READ;
    slot_d = cnt_d - CW'(WRCLK);
    for (int p = 0; p < NPORT; p++) begin
      rd_idx_d[p*IW +: IW] = IW'(p * RSLOTS) + IW'(slot_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= CW'(PERIOD - 1);
      strobe    <= 1'b0;
      wr_ready  <= 1'b0;
      wr_commit <= 1'b0;
      wr_index  <= '0;
      rd_valid  <= 1'b0;
      rd_idx    <= '0;
    end else begin
      cnt_q     <= cnt_d;
      strobe    <= (cnt_d == '0);
      wr_ready  <= (ph_d == PH_WRITE);
      wr_commit <= (ph_d == PH_WRITE) && cnt_d[0];
      wr_index  <= (ph_d == PH_WRITE) ? cnt_d[WORDW:1] : '0;
      rd_valid  <= (ph_d == PH_READ);
      rd_idx    <= (ph_d == PH_READ) ? rd_idx_d : '0;
    end
  end

endmodule

// File: rtl/smem_bank.sv
// One bank: simple dual-port RAM, one write port, one registered read port.
module smem_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int WORDW = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [WORDW-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [WORDW-1:0] raddr,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/smem_copy.sv
// One full copy of the array: NBANK banks written together, one read port.
module smem_copy #(
  parameter int DW     = 16,
  parameter int NBANK  = 18,
  parameter int BDEPTH = 16,
  parameter int WORDW  = 4,
  parameter int BANKW  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [WORDW-1:0]       waddr,
  input  logic [NBANK*DW-1:0]    wdata,
  input  logic                   rd_en,
  input  logic [BANKW+WORDW-1:0] raddr,
  output logic [DW-1:0]          rdata
);

  localparam int AW = BANKW + WORDW;

  logic [DW-1:0]    bank_q [NBANK];
  logic [BANKW-1:0] sel_q;
  logic             zero_q;
  logic             oor;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    smem_bank #(.DW(DW), .DEPTH(BDEPTH), .WORDW(WORDW)) u_bank (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata[b*DW +: DW]),
      .raddr (raddr[WORDW-1:0]),
      .rdata (bank_q[b])
    );
  end

  assign oor = ({1'b0, raddr[AW-1:WORDW]} >= (BANKW+1)'(NBANK));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      sel_q  <= raddr[AW-1:WORDW];
      zero_q <= !rd_en || oor;
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (!zero_q && sel_q == BANKW'(b)) rdata = bank_q[b];
    end
  end

endmodule

// File: rtl/smem_top.sv
// Banked shared signal memory with slot sequencer and optional mirrored copy.
module smem_top
  import smem_pkg::*;
#(
  parameter int DW     = 16,
  parameter int NBANK  = 18,
  parameter int BDEPTH = 16,
  parameter int NREAD  = 288,
  parameter int NPORT  = 1,
  localparam int WORDW  = bits_for(BDEPTH),
  localparam int BANKW  = bits_for(NBANK),
  localparam int AW     = BANKW + WORDW,
  localparam int IW     = bits_for(NREAD),
  localparam int RSLOTS = NREAD / NPORT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NBANK*DW-1:0] wr_data,
  input  logic [NPORT*AW-1:0] rd_addr,
  output logic                sample_strobe,
  output logic                wr_ready,
  output logic [WORDW-1:0]    wr_index,
  output logic                rd_valid,
  output logic [NPORT*IW-1:0] rd_idx,
  output logic                rd_dvalid,
  output logic [NPORT*IW-1:0] rd_didx,
  output logic [NPORT*DW-1:0] rd_data
);

  logic wr_commit;

  smem_seq #(
    .BDEPTH (BDEPTH),
    .RSLOTS (RSLOTS),
    .NPORT  (NPORT),
    .IW     (IW),
    .WORDW  (WORDW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .strobe    (sample_strobe),
    .wr_ready  (wr_ready),
    .wr_commit (wr_commit),
    .wr_index  (wr_index),
    .rd_valid  (rd_valid),
    .rd_idx    (rd_idx)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_copy
    smem_copy #(
      .DW     (DW),
      .NBANK  (NBANK),
      .BDEPTH (BDEPTH),
      .WORDW  (WORDW),
      .BANKW  (BANKW)
    ) u_copy (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_commit),
      .waddr (wr_index),
      .wdata (wr_data),
      .rd_en (rd_valid),
      .raddr (rd_addr[p*AW +: AW]),
      .rdata (rd_data[p*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_dvalid <= 1'b0;
      rd_didx   <= '0;
    end else begin
      rd_dvalid <= rd_valid;
      rd_didx   <= rd_idx;
    end
  end

endmodule

// File: rtl/smem_chk.sv
module smem_chk #(
  parameter int DW     = 16,
  parameter int NBANK  = 18,
  parameter int BDEPTH = 16,
  parameter int NPORT  = 1,
  parameter int RSLOTS = 288,
  parameter int WORDW  = 4,
  parameter int BANKW  = 5,
  parameter int IW     = 9
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   sample_strobe,
  input logic                   wr_ready,
  input logic [WORDW-1:0]       wr_index,
  input logic                   rd_valid,
  input logic [NPORT*IW-1:0]    rd_idx,
  input logic                   rd_dvalid,
  input logic [NPORT*IW-1:0]    rd_didx,
  input logic [NPORT*DW-1:0]    rd_data,
  input logic [BANKW+WORDW-1:0] addr0
);

  localparam int PERIOD = 2 * BDEPTH + RSLOTS;

  int  since_q;
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= 0;
      seen_q  <= 1'b0;
    end else if (sample_strobe) begin
      since_q <= 0;
      seen_q  <= 1'b1;
    end else begin
      since_q <= since_q + 1;
    end
  end

  p_period_r1: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (sample_strobe == (since_q == PERIOD - 1)));

  p_strobe_opens_r2: assert property (@(posedge clk) disable iff (rst)
    sample_strobe |-> (wr_ready && wr_index == '0));

  p_phase_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_ready && rd_valid));

  p_index_step_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && $past(wr_ready) && wr_index != $past(wr_index))
      |-> (wr_index == $past(wr_index) + 1'b1));

  p_dvalid_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_dvalid);

  p_no_dvalid_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !rd_dvalid);

  p_didx_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> (rd_didx == $past(rd_idx)));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_dvalid |-> (rd_data == '0));

  p_oor_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ({1'b0, addr0[BANKW+WORDW-1:WORDW]} >= (BANKW+1)'(NBANK)))
      |=> (rd_data[DW-1:0] == '0));

endmodule

bind smem_top smem_chk #(
  .DW     (DW),
  .NBANK  (NBANK),
  .BDEPTH (BDEPTH),
  .NPORT  (NPORT),
  .RSLOTS (RSLOTS),
  .WORDW  (WORDW),
  .BANKW  (BANKW),
  .IW     (IW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .sample_strobe (sample_strobe),
  .wr_ready      (wr_ready),
  .wr_index      (wr_index),
  .rd_valid      (rd_valid),
  .rd_idx        (rd_idx),
  .rd_dvalid     (rd_dvalid),
  .rd_didx       (rd_didx),
  .rd_data       (rd_data),
  .addr0         (rd_addr[AW-1:0])
);

// File: tb/sim_smem_top.sv
module sim_smem_top;

  localparam int CLK_P  = 10;
  localparam int DW     = 16;
  localparam int NBANK  = 18;
  localparam int BDEPTH = 16;
  localparam int NREAD  = 288;
  localparam int NPORT  = 2;
  localparam int WORDW  = $clog2(BDEPTH);
  localparam int BANKW  = $clog2(NBANK);
  localparam int AW     = BANKW + WORDW;
  localparam int IW     = $clog2(NREAD);
  localparam int RSLOTS = NREAD / NPORT;
  localparam int WRC    = 2 * BDEPTH;
  localparam int PERIOD = WRC + RSLOTS;
  localparam int NPER   = 4;

  logic                clk = 1'b0;
  logic                rst;
  logic [NBANK*DW-1:0] wr_data;
  logic [NPORT*AW-1:0] rd_addr;
  logic                sample_strobe, wr_ready, rd_valid, rd_dvalid;
  logic [WORDW-1:0]    wr_index;
  logic [NPORT*IW-1:0] rd_idx, rd_didx;
  logic [NPORT*DW-1:0] rd_data;

  always #(CLK_P/2) clk = ~clk;

  smem_top #(
    .DW(DW), .NBANK(NBANK), .BDEPTH(BDEPTH), .NREAD(NREAD), .NPORT(NPORT)
  ) u0 (
    .clk(clk), .rst(rst), .wr_data(wr_data), .rd_addr(rd_addr),
    .sample_strobe(sample_strobe), .wr_ready(wr_ready), .wr_index(wr_index),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_dvalid(rd_dvalid),
    .rd_didx(rd_didx), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [1:0]    kind;   // 0 in-range (R6), 1 out of range (R7), 2 mirrored (R8)
    logic [IW-1:0] idx;
    logic [DW-1:0] data;
  } exp_t;

  exp_t          sb[$];
  logic [DW-1:0] mdl [NBANK][BDEPTH];
  int            total = 0;
  int            bad   = 0;
  bit            done  = 1'b0;

  function automatic logic [DW-1:0] wval(input int k, input int b, input int w);
    return DW'(k * 4099 + b * 263 + w * 17 + 1);
  endfunction

  function automatic logic [AW-1:0] pick_addr(input int k, input int p, input int r);
    int idx;
    idx = p * RSLOTS + r;
    case (k % 4)
      0:       return AW'(idx);
      1:       return AW'(NREAD - 1 - idx);
      2:       return AW'((idx * 37 + 5) % (1 << AW));
      default: return AW'((r * 11) % NREAD);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pop expected items as read data appears.
  task automatic monitor();
    for (int p = 0; p < NPORT; p++) begin
      if (rd_dvalid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R5", "valid with nothing pending", 1, 0);
        end else begin
          exp_t e;
          string tag;
          e = sb.pop_front();
          tag = (e.kind == 2'd1) ? "R7" : (e.kind == 2'd2) ? "R8" : "R6";
          chk(rd_didx[p*IW +: IW] == e.idx, "R5", "returned index",
              rd_didx[p*IW +: IW], e.idx);
          chk(rd_data[p*DW +: DW] == e.data, tag, "read data",
              rd_data[p*DW +: DW], e.data);
        end
      end else begin
        chk(rd_data[p*DW +: DW] == '0, "R7", "data while not valid",
            rd_data[p*DW +: DW], 0);
      end
    end
    if (!rd_dvalid) chk(sb.size() == 0, "R5", "pending read not returned", sb.size(), 0);
  endtask

  // Driver: checks the slot outputs for this position and drives the inputs.
  task automatic step(input int k, input int pos);
    chk(sample_strobe == (pos == 0), "R1", "strobe", sample_strobe, pos == 0);
    if (pos < WRC) begin
      int w;
      w = pos / 2;
      chk(wr_ready == 1'b1 && rd_valid == 1'b0, "R2", "write phase flags",
          {wr_ready, rd_valid}, 2'b10);
      chk(wr_index == WORDW'(w), "R2", "write index", wr_index, w);
      chk(rd_idx == '0, "R4", "index outside read phase", rd_idx, 0);
      for (int b = 0; b < NBANK; b++) begin
        if (pos % 2 == 1) begin
          wr_data[b*DW +: DW] = wval(k, b, w);   // R3 sampled in second clock
          mdl[b][w] = wval(k, b, w);
        end else begin
          wr_data[b*DW +: DW] = ~wval(k, b, w);  // R10 first clock ignored
        end
      end
    end else begin
      int r;
      r = pos - WRC;
      chk(rd_valid == 1'b1 && wr_ready == 1'b0, "R4", "read phase flags",
          {wr_ready, rd_valid}, 2'b01);
      for (int b = 0; b < NBANK; b++) wr_data[b*DW +: DW] = DW'(16'hA5C3 ^ (pos * 7 + b));  // R10
      for (int p = 0; p < NPORT; p++) begin
        logic [AW-1:0] a;
        exp_t e;
        int bk, wd;
        chk(rd_idx[p*IW +: IW] == IW'(p * RSLOTS + r), "R4", "served index",
            rd_idx[p*IW +: IW], p * RSLOTS + r);
        a  = pick_addr(k, p, r);
        bk = int'(a[AW-1:WORDW]);
        wd = int'(a[WORDW-1:0]);
        rd_addr[p*AW +: AW] = a;
        e.idx  = IW'(p * RSLOTS + r);
        e.kind = (bk >= NBANK) ? 2'd1 : (k % 4 == 3) ? 2'd2 : 2'd0;
        e.data = (bk >= NBANK) ? '0 : mdl[bk][wd];
        sb.push_back(e);
      end
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    rst     = 1'b1;
    wr_data = '1;
    rd_addr = '0;
    for (int b = 0; b < NBANK; b++)
      for (int w = 0; w < BDEPTH; w++) mdl[b][w] = '0;
    repeat (4) @(negedge clk);
    chk(sample_strobe == 0 && wr_ready == 0 && rd_valid == 0 && rd_dvalid == 0,
        "R9", "flags in reset", {sample_strobe, wr_ready, rd_valid, rd_dvalid}, 0);
    chk(wr_index == '0 && rd_idx == '0 && rd_didx == '0, "R9", "indices in reset",
        rd_idx, 0);
    chk(rd_data == '0, "R9", "data in reset", rd_data, 0);
    rst = 1'b0;
    for (int n = 0; n <= NPER * PERIOD; n++) begin
      @(negedge clk);
      monitor();
      if (n < NPER * PERIOD) step(n / PERIOD, n % PERIOD);
      else chk(sample_strobe == 1'b1, "R1", "strobe after last period", sample_strobe, 1);
    end
    chk(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule